// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two direction predictors run side by side. The local component keeps a shift register of recent outcomes for each branch slot, chosen by low PC bits, and uses that history to pick a 2-bit saturating counter. The global component feeds the outcomes of the most recent branches, across all branches, into one shift register and uses it to pick a counter from its own table. A third table of 2-bit saturating counters is indexed by the same global history. For each history pattern it learns which of the two components has been right more often, and a multiplexer driven by that counter produces the final prediction.

Prediction is combinational from the fetch PC and the current table state. When a branch resolves, the pipeline returns its PC, the real outcome and the two component predictions it captured at fetch. Both components always learn from the outcome. The chooser learns only when the captured predictions disagreed. All histories and lookups at resolve come from the current state, so the block assumes that at most one branch is in flight between its fetch and its resolve.

Top module: `tbp_tournament`

## Requirements
- R1: While reset is active and on the first cycle after it, every counter holds 1 (weakly not taken) and every history holds zero. As a result `pred_local`, `pred_global` and `pred_taken` are 0 for any fetch PC.
- R2: Every counter is 2 bits wide and saturates at 0 and 3. A taken outcome adds one and a not-taken outcome subtracts one. A counter predicts taken when its value is 2 or 3.
- R3: PC bits [PC_LSB+LIDX_W-1:PC_LSB] select a local history entry. On resolve, the outcome shifts into bit 0 of that entry and older bits move up. The entry's LHIST_W-bit value indexes the local counter table, and that counter gives `pred_local`. PC bits outside the selecting field have no effect on `pred_local`.
- R4: The global history is a GHIST_W-bit shift register. Every resolve shifts its outcome into bit 0. The history indexes the global counter table, which gives `pred_global` with no dependence on the fetch PC.
- R5: The chooser counter indexed by the global history selects the output. A value of 2 or 3 gives `pred_taken = pred_global`, and 0 or 1 gives `pred_taken = pred_local`.
- R6: On resolve, the chooser counter at the current global history changes only when `res_local_pred` differs from `res_global_pred`. It steps up if the global capture equals the outcome and down otherwise. These captured inputs are used as given, not recomputed.
- R7: Every resolve updates the local counter addressed by the resolving branch's pre-shift local history, and the global counter addressed by the pre-shift global history. This happens whichever component the chooser selects.
- R8: With `res_valid` low, no state changes, whatever values the other resolve inputs carry.
- R9: A resolve at a clock edge is visible in the predictions from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Local component prediction for `fetch_pc` |
| pred_global | output | 1 | Global component prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_local_pred | input | 1 | Local prediction captured at fetch |
| res_global_pred | input | 1 | Global prediction captured at fetch |

## Verification
The bench uses a tiny configuration: 4 local slots, 3-bit histories and 8-entry counter tables. This lets a shadow model in the bench check every PC after each phase. The corner cases are as follows:
- Counters pushed past both limits. A design without saturation would wrap a strongly taken counter to strongly not taken and flip the prediction.
- Captured predictions driven in all four agree/disagree combinations, including ones that do not match the current state. A chooser that updated on agreement, or that recomputed the predictions, would steer the multiplexer to the wrong component.
- Cycles with `res_valid` low but garbage on the other resolve inputs. These catch any state that changes without a valid resolve.
- A second reset after heavy training. This exposes tables that are not fully cleared.

// File: rtl/tbp_pkg.sv
// Package: shared counter type and saturating step function for the
// tournament predictor. Assumes 2-bit counters throughout.
package tbp_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MAX  = '1;
    localparam ctr_t CTR_MIN  = '0;
    localparam ctr_t CTR_INIT = ctr_t'(1);

    // Move a counter one step toward taken (up=1) or not taken, clamped.
    function automatic ctr_t ctr_step(ctr_t c, logic up);
        if (up)
            return (c == CTR_MAX) ? c : c + ctr_t'(1);
        else
            return (c == CTR_MIN) ? c : c - ctr_t'(1);
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
// Module: table of 2-bit saturating counters with one combinational read
// port and one read-modify-write update port. Assumes at most one update
// per cycle; the read port shows the value before that cycle's update.
module tbp_ctr_table
    import tbp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    // Lookup for the prediction path.
    assign rd_ctr = mem[rd_idx];

    // Reset every counter to weakly not taken, else apply one saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= CTR_INIT;
            end
        end else if (upd_en) begin
            mem[upd_idx] <= ctr_step(mem[upd_idx], upd_up);
        end
    end

endmodule

// File: rtl/tbp_local_hist.sv
// Module: first-level table of per-slot outcome histories. Two read ports
// (fetch and resolve) and one shift update port. The newest outcome enters at bit 0.
// Assumes HIST_W >= 2.
module tbp_local_hist #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  fetch_idx,
    output logic [HIST_W-1:0] fetch_hist,
    input  logic [IDX_W-1:0]  res_idx,
    output logic [HIST_W-1:0] res_hist,
    input  logic              upd_en,
    input  logic              upd_bit
);

    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    // Read the history seen by the fetching branch.
    assign fetch_hist = hist[fetch_idx];
    // Read the history seen by the resolving branch.
    assign res_hist   = hist[res_idx];

    // Clear all histories on reset, else shift the outcome into the resolving slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist[i] <= '0;
            end
        end else if (upd_en) begin
            hist[res_idx] <= {hist[res_idx][HIST_W-2:0], upd_bit};
        end
    end

endmodule

// File: rtl/tbp_tournament.sv
// Module: tournament direction predictor. The local and global components
// run in parallel, and a chooser counter table indexed by global history
// selects between them. Assumes one branch in flight: histories used at
// resolve are the current ones, which equal those seen at fetch.
// Assumes PC_LSB >= 1 and PC_LSB + LIDX_W < PC_W.
module tbp_tournament
    import tbp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10,
    parameter int GHIST_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_local_pred,
    input  logic            res_global_pred
);

    localparam int IDX_HI = PC_LSB + LIDX_W - 1;

    logic [LIDX_W-1:0]  fetch_slot;
    logic [LIDX_W-1:0]  res_slot;
    logic [LHIST_W-1:0] fetch_lhist;
    logic [LHIST_W-1:0] res_lhist;
    logic [GHIST_W-1:0] ghist;
    ctr_t               lctr_rd;
    ctr_t               gctr_rd;
    ctr_t               chooser_rd;
    logic               chooser_upd;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_HI+1], fetch_pc[PC_LSB-1:0],
                              res_pc[PC_W-1:IDX_HI+1],   res_pc[PC_LSB-1:0]};

    // Slot selection from the PC field above the alignment bits.
    assign fetch_slot = fetch_pc[IDX_HI:PC_LSB];
    assign res_slot   = res_pc[IDX_HI:PC_LSB];

    tbp_local_hist #(
        .IDX_W  (LIDX_W),
        .HIST_W (LHIST_W)
    ) lhist_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_idx  (fetch_slot),
        .fetch_hist (fetch_lhist),
        .res_idx    (res_slot),
        .res_hist   (res_lhist),
        .upd_en     (res_valid),
        .upd_bit    (res_taken)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W)) lctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_lhist),
        .rd_ctr  (lctr_rd),
        .upd_en  (res_valid),
        .upd_idx (res_lhist),
        .upd_up  (res_taken)
    );

    tbp_ctr_table #(.IDX_W(GHIST_W)) gctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_ctr  (gctr_rd),
        .upd_en  (res_valid),
        .upd_idx (ghist),
        .upd_up  (res_taken)
    );

    // Chooser learns only when the captured component predictions differ.
    assign chooser_upd = res_valid && (res_local_pred != res_global_pred);

    tbp_ctr_table #(.IDX_W(GHIST_W)) chooser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_ctr  (chooser_rd),
        .upd_en  (chooser_upd),
        .upd_idx (ghist),
        .upd_up  (res_global_pred == res_taken)
    );

    // Global outcome history, cleared on reset, shifted on every resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist <= '0;
        end else if (res_valid) begin
            ghist <= {ghist[GHIST_W-2:0], res_taken};
        end
    end

    // Component predictions from the counter MSB, and the final multiplexer.
    always_comb begin
        pred_local  = lctr_rd[CTR_W-1];
        pred_global = gctr_rd[CTR_W-1];
        pred_taken  = chooser_rd[CTR_W-1] ? pred_global : pred_local;
    end

endmodule

// File: rtl/tbp_tournament_chk.sv
// Module: property checker for tbp_tournament, attached by bind.
// Observes ports only and assumes the synchronous active-low reset.
module tbp_tournament_chk #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int LIDX_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            res_valid,
    input logic            pred_taken,
    input logic            pred_local,
    input logic            pred_global
);

    localparam int IDX_HI = PC_LSB + LIDX_W - 1;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pred_taken && !pred_local && !pred_global));

    // R5
    agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(res_valid) && $stable(fetch_pc))
        |-> ($stable(pred_taken) && $stable(pred_local) && $stable(pred_global)));

    // R4
    global_pc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(res_valid)) |-> $stable(pred_global));

    // R3
    local_slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(res_valid) && $stable(fetch_pc[IDX_HI:PC_LSB]))
        |-> $stable(pred_local));

endmodule

bind tbp_tournament tbp_tournament_chk #(
    .PC_W   (PC_W),
    .PC_LSB (PC_LSB),
    .LIDX_W (LIDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_pc    (fetch_pc),
    .res_valid   (res_valid),
    .pred_taken  (pred_taken),
    .pred_local  (pred_local),
    .pred_global (pred_global)
);

// File: tb/tbp_tournament_tb.sv
// Bench: small configuration with a shadow model of every table; all PCs
// are swept after each phase.
module tbp_tournament_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W    = 8;
    localparam int PC_LSB  = 2;
    localparam int LIDX_W  = 2;
    localparam int LHIST_W = 3;
    localparam int GHIST_W = 3;
    localparam int NPC     = 1 << PC_W;
    localparam int IDX_HI  = PC_LSB + LIDX_W - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken, pred_local, pred_global;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0;
    logic            res_local_pred = 1'b0;
    logic            res_global_pred = 1'b0;

    logic [LHIST_W-1:0] m_lht  [1 << LIDX_W];
    logic [1:0]         m_lctr [1 << LHIST_W];
    logic [1:0]         m_gctr [1 << GHIST_W];
    logic [1:0]         m_ch   [1 << GHIST_W];
    logic [GHIST_W-1:0] m_gh;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbp_tournament #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W),
        .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_local_pred(res_local_pred), .res_global_pred(res_global_pred)
    );

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic lfsr_next();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic model_reset();
        for (int i = 0; i < (1 << LIDX_W); i++) m_lht[i] = '0;
        for (int i = 0; i < (1 << LHIST_W); i++) m_lctr[i] = 2'd1;
        for (int i = 0; i < (1 << GHIST_W); i++) begin
            m_gctr[i] = 2'd1;
            m_ch[i]   = 2'd1;
        end
        m_gh = '0;
    endtask

    task automatic chk(string tag, logic got, logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, compare after settling, update model after the edge.
    task automatic step(string ph, logic [PC_W-1:0] pc, logic rv, logic [PC_W-1:0] rpc,
                        logic rt, logic rl, logic rg, output logic el, output logic eg);
        logic [LHIST_W-1:0] h;
        logic et;
        @(negedge clk);
        fetch_pc = pc; res_valid = rv; res_pc = rpc;
        res_taken = rt; res_local_pred = rl; res_global_pred = rg;
        #1;
        el = m_lctr[m_lht[pc[IDX_HI:PC_LSB]]][1];
        eg = m_gctr[m_gh][1];
        et = m_ch[m_gh][1] ? eg : el;
        chk({ph, " R3 local"},  pred_local,  el);
        chk({ph, " R4 global"}, pred_global, eg);
        chk({ph, " R5 final"},  pred_taken,  et);
        @(posedge clk);
        if (rv && rst_n) begin
            h = m_lht[rpc[IDX_HI:PC_LSB]];
            m_lctr[h] = sat(m_lctr[h], rt);
            m_lht[rpc[IDX_HI:PC_LSB]] = {h[LHIST_W-2:0], rt};
            m_gctr[m_gh] = sat(m_gctr[m_gh], rt);
            if (rl != rg) m_ch[m_gh] = sat(m_ch[m_gh], rg == rt);
            m_gh = {m_gh[GHIST_W-2:0], rt};
        end
    endtask

    task automatic sweep(string ph);
        logic l, g;
        for (int p = 0; p < NPC; p++) step(ph, p[PC_W-1:0], 1'b0, '0, 1'b0, 1'b0, 1'b0, l, g);
    endtask

    task automatic do_reset();
        logic l, g;
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            res_valid = 1'b1; res_taken = 1'b1; res_pc = 8'h14;
            res_local_pred = 1'b0; res_global_pred = 1'b1;
        end
        @(negedge clk);
        rst_n = 1'b1; res_valid = 1'b0;
        step("R1", 8'h00, 1'b0, '0, 1'b0, 1'b0, 1'b0, l, g);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic l, g, pl, pg, t;
        logic [PC_W-1:0] ppc;
        model_reset();
        // R1: reset state, all predictions zero for every PC.
        do_reset();
        sweep("R1");

        // R8: garbage on resolve fields with valid low changes nothing.
        for (int i = 0; i < 40; i++) begin
            lfsr_next();
            step("R8", lfsr[7:0], 1'b0, lfsr[15:8], lfsr[3], lfsr[5], lfsr[9], l, g);
        end
        sweep("R8");

        // R2: drive one branch taken past saturation, then not taken past zero.
        for (int i = 0; i < 12; i++) begin
            step("R2", 8'h24, 1'b1, 8'h24, i < 6, 1'b1, 1'b1, l, g);
        end
        sweep("R2");

        // R6: all agree/disagree combinations of captured predictions vs outcome.
        for (int i = 0; i < 256; i++) begin
            step("R6", i[7:0], 1'b1, {i[7:2], 2'b00}, i[0], i[1], i[2], l, g);
        end
        sweep("R6");

        // R7: component that is not selected still learns; periodic pattern per slot.
        for (int i = 0; i < 200; i++) begin
            t = (i % 3) != 0;
            step("R7", {2'b00, i[1:0], 2'b00}, 1'b1, {2'b00, i[1:0], 2'b00}, t, ~t, t, l, g);
        end
        sweep("R7");

        // R9: realistic flow, resolve the previous fetch with its captured predictions.
        ppc = '0; pl = 1'b0; pg = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            lfsr_next();
            t = lfsr[0] | (lfsr[3] & ppc[2]);
            step("R9", lfsr[11:4], i > 0, ppc, t, pl, pg, l, g);
            ppc = lfsr[11:4]; pl = l; pg = g;
        end
        sweep("R9");

        // R1: a second reset after training clears every table.
        do_reset();
        sweep("R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule